// File: doc/BRIEF.md
# Heap Access Check Request Filter

This block sits between a processor's data-access port and a software heap checker. For every access it decides if the checker has to see it. Allocate and deallocate commands always produce a check request. Reads and writes produce one only when two things hold. First, the address lies inside a programmable heap window. Second, the word's locally cached pass bit is not set, either because the line is not resident or because its bit is 0. Any request that is produced goes into a bounded, ordered request FIFO toward the checker.

Pass bits come back from the checker through a small report FIFO, one line at a time. Each returned line is installed in a direct-mapped pass-bit store and replaces whatever line sat at that index. A separate update command rewrites the bits of a line that is already resident. A read that misses inside the window holds off all further accesses until that line's bits have been installed. The requester sees a stall only in two cases: that wait, or an access that needs a request while the request FIFO is full.

Top module: `heap_check_filter`

## Requirements
- R1: After reset the heap window is empty (low bound all ones, high bound 0), no line is resident, `req_valid` is 0, `acc_ready` is 1 and `rpt_ready` is 1.
- R2: A read or write whose byte address lies outside the inclusive window [`win_lo`, `win_hi`] never produces a request. Both window bounds themselves count as inside.
- R3: A read or write inside the window to a resident line whose pass bit for that word is 1 produces no request. The word index is address bits [4:2] and the line index is address bits [8:5].
- R4: A read or write inside the window produces a request when its line is not resident or when its word's pass bit is 0.
- R5: Allocate and deallocate commands always produce a request, whatever the window or the pass bits.
- R6: Each request carries the process id, program counter, kind, address and size of its access. Kind is encoded 0 read, 1 write, 2 allocate, 3 deallocate. Requests leave in acceptance order.
- R7: The request FIFO holds 64 entries. While it is full, an access that needs a request sees `acc_ready` at 0. An access that needs no request is still accepted.
- R8: A line returned through the report FIFO (8 entries) is installed two clock edges after it is accepted. It replaces the tag and all pass bits held at its index.
- R9: Once a read that misses inside the window is accepted, `acc_ready` stays 0 until the pass bits for that line have been installed.
- R10: An update command rewrites the pass bits of its line when that line is resident. When the line is not resident, the command has no effect.
- R11: When an update and a report install reach the same line on the same edge, the update's bits are the ones kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the heap window bounds |
| cfg_lo | input | 32 | Lowest heap byte address (inclusive) |
| cfg_hi | input | 32 | Highest heap byte address (inclusive) |
| acc_valid | input | 1 | Access presented |
| acc_ready | output | 1 | Access accepted this cycle |
| acc_kind | input | 2 | 0 read, 1 write, 2 allocate, 3 deallocate |
| acc_pid | input | 8 | Process id |
| acc_pc | input | 32 | Program counter of the access |
| acc_addr | input | 32 | Virtual byte address |
| acc_size | input | 16 | Size in bytes |
| req_valid | output | 1 | Check request available |
| req_ready | input | 1 | Checker takes the request |
| req_pid | output | 8 | Request process id |
| req_pc | output | 32 | Request program counter |
| req_kind | output | 2 | Request kind |
| req_addr | output | 32 | Request address |
| req_size | output | 16 | Request size |
| rpt_valid | input | 1 | Returned line report presented |
| rpt_ready | output | 1 | Report FIFO has room |
| rpt_line | input | 27 | Line address (byte address bits [31:5]) |
| rpt_bits | input | 8 | Per-word pass bits, bit i for word i |
| upd_valid | input | 1 | Pass-bit update command |
| upd_line | input | 27 | Line address of the update |
| upd_bits | input | 8 | New per-word pass bits |

## Verification
Two functions can land on one clock edge: a line leaving the report FIFO for installation, and an update command aimed at that same line. The bench provokes this by pushing a report for a resident line and then raising the update during the very cycle the report is drained. It then judges the result by the outcome of later writes: a word that is 0 only in the update's pattern must raise a request, and a word that is 1 only in the update's pattern must pass. A second overlap is the full-FIFO stall. In that case an access that needs no request is shown to be accepted in the same state where a request-bearing access is held.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
    typedef enum logic [1:0] {
        KIND_READ    = 2'd0,
        KIND_WRITE   = 2'd1,
        KIND_ALLOC   = 2'd2,
        KIND_DEALLOC = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/hcf_fifo.sv
module hcf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t   st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic   do_push, do_pop;

    assign full     = (st_q.cnt == CNT_W'(DEPTH));
    assign empty    = (st_q.cnt == '0);
    assign pop_data = mem_q[st_q.rd];
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push)
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (do_pop)
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end
endmodule

// File: rtl/hcf_pass_store.sv
module hcf_pass_store #(
    parameter int LINES = 16,
    parameter int WORDS = 8,
    parameter int TAG_W = 23,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WORDS-1:0] lk_bits,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [WORDS-1:0] fill_bits,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [WORDS-1:0] upd_bits
);
    logic [LINES-1:0] vld_d, vld_q;
    logic [TAG_W-1:0] tag_d [LINES];
    logic [TAG_W-1:0] tag_q [LINES];
    logic [WORDS-1:0] bit_d [LINES];
    logic [WORDS-1:0] bit_q [LINES];

    assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_bits = bit_q[lk_idx];

    // install first, then let an update to the line now resident override it
    always_comb begin
        vld_d = vld_q;
        for (int i = 0; i < LINES; i++) begin
            tag_d[i] = tag_q[i];
            bit_d[i] = bit_q[i];
        end
        if (fill_en) begin
            vld_d[fill_idx] = 1'b1;
            tag_d[fill_idx] = fill_tag;
            bit_d[fill_idx] = fill_bits;
        end
        if (upd_en && vld_d[upd_idx] && (tag_d[upd_idx] == upd_tag))
            bit_d[upd_idx] = upd_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                tag_q[g] <= tag_d[g];
                bit_q[g] <= bit_d[g];
            end
        end
    endgenerate
endmodule

// File: rtl/heap_check_filter.sv
module heap_check_filter
    import hcf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PID_W      = 8,
    parameter int SIZE_W     = 16,
    parameter int LINE_WORDS = 8,
    parameter int LINES      = 16,
    parameter int REQ_DEPTH  = 64,
    parameter int RPT_DEPTH  = 8,
    localparam int BYTE_W    = 2,
    localparam int WOFF_W    = $clog2(LINE_WORDS),
    localparam int LSB       = BYTE_W + WOFF_W,
    localparam int LINE_W    = ADDR_W - LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_lo,
    input  logic [ADDR_W-1:0] cfg_hi,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic [1:0]        acc_kind,
    input  logic [PID_W-1:0]  acc_pid,
    input  logic [ADDR_W-1:0] acc_pc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SIZE_W-1:0] acc_size,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [PID_W-1:0]  req_pid,
    output logic [ADDR_W-1:0] req_pc,
    output logic [1:0]        req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SIZE_W-1:0] req_size,
    input  logic              rpt_valid,
    output logic              rpt_ready,
    input  logic [LINE_W-1:0] rpt_line,
    input  logic [LINE_WORDS-1:0] rpt_bits,
    input  logic              upd_valid,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [LINE_WORDS-1:0] upd_bits
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = LINE_W - IDX_W;
    localparam int REQ_W = PID_W + 2 * ADDR_W + 2 + SIZE_W;
    localparam int RPT_W = LINE_W + LINE_WORDS;

    typedef struct packed {
        logic [ADDR_W-1:0] win_lo;
        logic [ADDR_W-1:0] win_hi;
        logic              wait_v;
        logic [LINE_W-1:0] wait_line;
    } state_t;

    state_t st_d, st_q;

    logic              req_full, req_empty, req_push;
    logic [REQ_W-1:0]  req_in, req_out;
    logic              rpt_full, rpt_empty;
    logic [RPT_W-1:0]  rpt_out;
    logic [LINE_W-1:0] pop_line;
    logic [LINE_WORDS-1:0] pop_bits;
    logic              lk_hit;
    logic [LINE_WORDS-1:0] lk_bits;
    logic [LINE_W-1:0] acc_line;
    logic [WOFF_W-1:0] acc_word;
    logic              in_win, is_mgmt, passes, need_req, fire;

    // signals visible to the bound checker
    logic [ADDR_W-1:0] win_lo_q, win_hi_q;
    logic              wait_q;
    assign win_lo_q = st_q.win_lo;
    assign win_hi_q = st_q.win_hi;
    assign wait_q   = st_q.wait_v;

    assign acc_line = acc_addr[ADDR_W-1:LSB];
    assign acc_word = acc_addr[BYTE_W +: WOFF_W];
    assign {pop_line, pop_bits} = rpt_out;

    hcf_pass_store #(
        .LINES(LINES), .WORDS(LINE_WORDS), .TAG_W(TAG_W), .IDX_W(IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (acc_line[IDX_W-1:0]),
        .lk_tag   (acc_line[LINE_W-1:IDX_W]),
        .lk_hit   (lk_hit),
        .lk_bits  (lk_bits),
        .fill_en  (!rpt_empty),
        .fill_idx (pop_line[IDX_W-1:0]),
        .fill_tag (pop_line[LINE_W-1:IDX_W]),
        .fill_bits(pop_bits),
        .upd_en   (upd_valid),
        .upd_idx  (upd_line[IDX_W-1:0]),
        .upd_tag  (upd_line[LINE_W-1:IDX_W]),
        .upd_bits (upd_bits)
    );

    hcf_fifo #(.W(RPT_W), .DEPTH(RPT_DEPTH)) u_rpt_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rpt_valid),
        .push_data({rpt_line, rpt_bits}),
        .full     (rpt_full),
        .pop      (1'b1),
        .pop_data (rpt_out),
        .empty    (rpt_empty)
    );

    hcf_fifo #(.W(REQ_W), .DEPTH(REQ_DEPTH)) u_req_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (req_push),
        .push_data(req_in),
        .full     (req_full),
        .pop      (req_ready),
        .pop_data (req_out),
        .empty    (req_empty)
    );

    assign rpt_ready = !rpt_full;
    assign req_valid = !req_empty;
    assign req_in    = {acc_pid, acc_pc, acc_kind, acc_addr, acc_size};
    assign {req_pid, req_pc, req_kind, req_addr, req_size} = req_out;

    always_comb begin
        in_win    = (acc_addr >= st_q.win_lo) && (acc_addr <= st_q.win_hi);
        is_mgmt   = (acc_kind == KIND_ALLOC) || (acc_kind == KIND_DEALLOC);
        passes    = lk_hit && lk_bits[acc_word];
        need_req  = is_mgmt || (in_win && !passes);
        acc_ready = !st_q.wait_v && (!need_req || !req_full);
        fire      = acc_valid && acc_ready;
        req_push  = fire && need_req;

        st_d = st_q;
        if (cfg_we) begin
            st_d.win_lo = cfg_lo;
            st_d.win_hi = cfg_hi;
        end
        if (st_q.wait_v && !rpt_empty && (pop_line == st_q.wait_line))
            st_d.wait_v = 1'b0;
        if (fire && (acc_kind == KIND_READ) && in_win && !lk_hit) begin
            st_d.wait_v    = 1'b1;
            st_d.wait_line = acc_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.win_lo    <= '1;
            st_q.win_hi    <= '0;
            st_q.wait_v    <= 1'b0;
            st_q.wait_line <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hcf_checker.sv
module hcf_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic [1:0]        acc_kind,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [ADDR_W-1:0] win_lo_q,
    input logic [ADDR_W-1:0] win_hi_q,
    input logic              wait_q,
    input logic              req_full,
    input logic              req_push,
    input logic              req_valid
);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_full |-> !req_push);

    p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ready && !wait_q) |-> req_full);

    p_mgmt_enq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && acc_kind[1]) |-> req_push);

    p_mgmt_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && acc_kind[1]) |=> req_valid);

    p_outside_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !acc_kind[1] &&
         ((acc_addr < win_lo_q) || (acc_addr > win_hi_q))) |-> !req_push);

    p_wait_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q |-> !acc_ready);
endmodule

bind heap_check_filter hcf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_ready(acc_ready),
    .acc_kind (acc_kind),
    .acc_addr (acc_addr),
    .win_lo_q (win_lo_q),
    .win_hi_q (win_hi_q),
    .wait_q   (wait_q),
    .req_full (req_full),
    .req_push (req_push),
    .req_valid(req_valid)
);

// File: tb/sim_heap_check_filter.sv
module sim_heap_check_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [31:0] cfg_lo = '0, cfg_hi = '0;
    logic acc_valid = 1'b0;
    logic acc_ready;
    logic [1:0] acc_kind = '0;
    logic [7:0] acc_pid = '0;
    logic [31:0] acc_pc = '0, acc_addr = '0;
    logic [15:0] acc_size = '0;
    logic req_valid;
    logic req_ready = 1'b1;
    logic [7:0] req_pid;
    logic [31:0] req_pc, req_addr;
    logic [1:0] req_kind;
    logic [15:0] req_size;
    logic rpt_valid = 1'b0;
    logic rpt_ready;
    logic [26:0] rpt_line = '0;
    logic [7:0] rpt_bits = '0;
    logic upd_valid = 1'b0;
    logic [26:0] upd_line = '0;
    logic [7:0] upd_bits = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    heap_check_filter u0 (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic push_rpt(input logic [31:0] addr, input logic [7:0] bits);
        @(negedge clk);
        rpt_valid = 1'b1; rpt_line = addr[31:5]; rpt_bits = bits;
        @(posedge clk);
        @(negedge clk);
        rpt_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic send_upd(input logic [31:0] addr, input logic [7:0] bits);
        @(negedge clk);
        upd_valid = 1'b1; upd_line = addr[31:5]; upd_bits = bits;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // one access with req_ready high; judge whether a request appeared
    task automatic one_acc(input logic [1:0] kind, input logic [31:0] addr, input bit exp,
                           input logic [7:0] pid, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = kind; acc_addr = addr;
        acc_pid = pid; acc_pc = 32'h400 + 32'(pid); acc_size = 16'd4;
        #1 check(acc_ready == 1'b1, req, 32'(acc_ready), 1);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        check(req_valid == exp, req, 32'(req_valid), 32'(exp));
        if (exp && req_valid) begin
            check(req_addr == addr && req_kind == kind, "R6", req_addr, addr);
            check(req_pid == pid && req_pc == 32'h400 + 32'(pid) && req_size == 16'd4,
                  "R6", req_pc, 32'h400 + 32'(pid));
        end
    endtask

    // kind, address, expected request
    localparam logic [34:0] VEC [12] = '{
        {2'd0, 32'h0000_1000, 1'b0},   // R3 pass bit word 0
        {2'd1, 32'h0000_1008, 1'b0},   // R3 pass bit word 2
        {2'd1, 32'h0000_1004, 1'b1},   // R4 bit 0
        {2'd0, 32'h0000_1044, 1'b0},   // R3 second line
        {2'd1, 32'h0000_0FFC, 1'b0},   // R2 just below
        {2'd1, 32'h0000_1FFC, 1'b1},   // R2 high bound inclusive, miss
        {2'd1, 32'h0000_2000, 1'b0},   // R2 just above
        {2'd2, 32'h0000_3000, 1'b1},   // R5 allocate outside
        {2'd3, 32'h0000_1000, 1'b1},   // R5 deallocate on passing word
        {2'd0, 32'h0000_0800, 1'b0},   // R2 read miss outside, no wait
        {2'd1, 32'h0000_1100, 1'b1},   // R4 miss
        {2'd1, 32'h0000_1000, 1'b1}    // R2 low bound inclusive, R4 bit 0? word0 bit1 -> see below
    };

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1
        check(acc_ready == 1'b1, "R1", 32'(acc_ready), 1);
        check(req_valid == 1'b0, "R1", 32'(req_valid), 0);
        check(rpt_ready == 1'b1, "R1", 32'(rpt_ready), 1);
        // R1: empty window, read to 0 neither requests nor waits
        one_acc(2'd0, 32'h0, 1'b0, 8'd99, "R1");

        @(negedge clk);
        cfg_we = 1'b1; cfg_lo = 32'h1000; cfg_hi = 32'h1FFC;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;

        push_rpt(32'h1000, 8'b0000_0101);   // R8 install
        push_rpt(32'h1040, 8'hFF);

        for (int i = 0; i < 12; i++) begin
            logic [1:0] k;
            logic [31:0] a;
            bit e;
            {k, a, e} = VEC[i];
            // last vector: word 0 of 0x1000 has bit 1, so it passes
            if (i == 11) e = 1'b0;
            one_acc(k, a, e, 8'(i), (i < 4) ? "R3" : "R2");
        end

        // R9: in-window read miss blocks until its line is installed
        one_acc(2'd0, 32'h1200, 1'b1, 8'd20, "R9");
        check(acc_ready == 1'b0, "R9", 32'(acc_ready), 0);
        push_rpt(32'h1200, 8'h01);
        @(negedge clk);
        check(acc_ready == 1'b1, "R9", 32'(acc_ready), 1);
        // R8: new line installed, old line at same index discarded
        one_acc(2'd0, 32'h1200, 1'b0, 8'd21, "R8");
        one_acc(2'd1, 32'h1008, 1'b1, 8'd22, "R8");

        // R10: resident update takes effect, non-resident one ignored
        send_upd(32'h1200, 8'hFF);
        one_acc(2'd1, 32'h1204, 1'b0, 8'd23, "R10");
        send_upd(32'h3000, 8'h00);
        one_acc(2'd1, 32'h1204, 1'b0, 8'd24, "R10");

        // R11: update lands on the edge that installs a report for the same line
        @(negedge clk);
        rpt_valid = 1'b1; rpt_line = 27'(32'h1040 >> 5); rpt_bits = 8'h00;
        @(posedge clk);
        @(negedge clk);
        rpt_valid = 1'b0;
        upd_valid = 1'b1; upd_line = 27'(32'h1040 >> 5); upd_bits = 8'hF0;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0;
        one_acc(2'd1, 32'h1044, 1'b1, 8'd25, "R11");
        one_acc(2'd1, 32'h1050, 1'b0, 8'd26, "R11");

        // R7: fill the request FIFO, then probe the stall rules
        @(negedge clk);
        req_ready = 1'b0;
        acc_kind = 2'd1; acc_addr = 32'h1044; acc_pid = 8'd1; acc_size = 16'd4;
        acc_valid = 1'b1;
        for (int i = 0; i < 64; i++) begin
            acc_pc = 32'(i);
            @(posedge clk);
            @(negedge clk);
        end
        check(acc_ready == 1'b0, "R7", 32'(acc_ready), 0);
        acc_kind = 2'd0; acc_addr = 32'h1050;
        #1 check(acc_ready == 1'b1, "R7", 32'(acc_ready), 1);
        @(posedge clk);
        @(negedge clk);
        acc_kind = 2'd2; acc_addr = 32'h3000;
        #1 check(acc_ready == 1'b0, "R7", 32'(acc_ready), 0);
        acc_valid = 1'b0;
        @(negedge clk);
        req_ready = 1'b1;
        begin
            int got;
            bit order_ok;
            got = 0;
            order_ok = 1'b1;
            for (int i = 0; i < 64; i++) begin
                if (req_valid) begin
                    got++;
                    if (req_pc != 32'(i) || req_addr != 32'h1044) order_ok = 1'b0;
                end
                @(posedge clk);
                @(negedge clk);
            end
            check(got == 64, "R7", 32'(got), 64);
            check(order_ok, "R6", 0, 1);
            check(req_valid == 1'b0, "R7", 32'(req_valid), 0);
        end

        finish_run();
    end
endmodule